// File: doc/BRIEF.md
# Interleaved Multi-Phase PWM Generator

This block turns one duty command into two to four pulse-width-modulated outputs whose switching instants are spread evenly over a common period. A free-running period counter serves every channel. Each channel compares its own phase-shifted view of that counter against its own corrected duty value. The combined ripple seen at the load therefore repeats at the channel rate times the number of active channels.

Right after reset the block reads a strap input for each optional channel and fixes how many channels take part. It keeps that count until the next reset. Every active channel also receives a signed correction to its duty. The correction is derived from the gap between the mean of all active current samples and that channel's own sample, so a channel carrying more than its share switches on for less time.

Each output has a data bit and an enable bit, so a pin can be driven high, driven low or released. Two control inputs override normal switching. One releases every pin. The other pulls every active pin low, and it takes priority over the release request.

Top module: `mpwm_top`

## Requirements
- R1: While reset is asserted, and on the first clock edge after it is released, every data bit and every enable bit is 0.
- R2: On the first clock edge after reset release, the active count is latched. Channels 0 and 1 are always active. Channel k (k >= 2) is active only if its strap bit `chan_unused_i[k]` is 0 and channel k-1 is active. Strap changes after that edge have no effect until the next reset.
- R3: The enable bit of an inactive channel is always 0, and its data bit is 0.
- R4: The period counter starts at 0 on the latching edge, then advances by one per clock and wraps from PERIOD-1 to 0. Every output is registered: the value seen after an edge is computed from the counter value and the inputs just before that edge.
- R5: Channel k of n active channels has offset floor(k*PERIOD/n). Its local count is (counter - offset) mod PERIOD, and its data bit is 1 exactly when the local count is below its corrected duty. Channel 0 is therefore the phase reference.
- R6: The mean is floor(sum of active samples / n). Each channel's trim is floor((mean - own sample) / 2^TRIM_SHIFT). The corrected duty is duty_cmd + trim, clamped to the range 0 to PERIOD. Samples of inactive channels take no part in the mean.
- R7: While `tri_req_i` is 1 and `low_req_i` is 0, every enable bit and every data bit is 0 after the next edge.
- R8: While `low_req_i` is 1 (and the count is latched), every active channel has enable 1 and data 0 after the next edge, whatever `tri_req_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_cmd_i | input | DW (8) | Shared duty command, in counter steps |
| isen_i | input | NCH*IW (32) | Sampled current per channel, channel k in bits [k*IW +: IW] |
| chan_unused_i | input | NCH-2 (2), indices NCH-1:2 | Strap per optional channel, 1 = not fitted |
| tri_req_i | input | 1 | Release every output |
| low_req_i | input | 1 | Drive every active output low (has priority) |
| pwm_o | output | NCH (4) | Data bit per channel |
| pwm_oe_o | output | NCH (4) | Output enable per channel |

## Verification
The embedded properties assume that the straps are meaningful only at the latching edge, and that the override inputs and the duty command are synchronous to the clock. The bench therefore changes every input half a period away from the active edge. It changes the straps only while reset is held, except for one deliberate change after latching that tests that such a change is ignored. Current samples and duty commands are chosen so that the trims take both signs and the clamp is hit at zero and at PERIOD. The straps cover two, three and four active channels, and the sample of an inactive channel is made extreme so that leaking it into the mean would show.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

  // Phase offset of channel k when n channels share a period of per counts
  function automatic int phase_offset(int k, int n, int per);
    if (n <= 0) return 0;
    return (k * per) / n;
  endfunction

  // Mean of the active samples, truncated toward zero (operands are non-negative)
  function automatic int mean_of(int total, int n);
    if (n <= 0) return 0;
    return total / n;
  endfunction

  // Balancing trim: arithmetic shift gives floor division by 2^sh
  function automatic int trim_of(int avg, int sample, int sh);
    return (avg - sample) >>> sh;
  endfunction

  // Saturate a corrected duty into [0, hi]
  function automatic int clamp_to(int v, int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/mpwm_detect.sv
module mpwm_detect #(
  parameter int NCH    = 4,
  parameter int PERIOD = 240,
  parameter int CW     = 8,
  parameter int NW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:2]    strap_i,
  output logic              done_o,
  output logic [NW-1:0]     n_act_o,
  output logic [NCH-1:0]    act_mask_o,
  output logic [NCH*CW-1:0] off_flat_o
);

  logic [NCH-1:0]    act_c;
  logic [NW-1:0]     n_c;
  logic [NCH*CW-1:0] off_c;

  // Active channels form an unbroken run from channel 0
  always_comb begin
    logic run;
    run      = 1'b1;
    act_c    = '0;
    act_c[0] = 1'b1;
    act_c[1] = 1'b1;
    for (int k = 2; k < NCH; k++) begin
      run      = run & ~strap_i[k];
      act_c[k] = run;
    end
  end

  assign n_c = NW'($countones(act_c));

  always_comb begin
    off_c = '0;
    for (int k = 0; k < NCH; k++) begin
      off_c[k*CW +: CW] = CW'(mpwm_pkg::phase_offset(k, int'(n_c), PERIOD));
    end
  end

  // Latched exactly once per reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o     <= 1'b0;
      n_act_o    <= '0;
      act_mask_o <= '0;
      off_flat_o <= '0;
    end else if (!done_o) begin
      done_o     <= 1'b1;
      n_act_o    <= n_c;
      act_mask_o <= act_c;
      off_flat_o <= off_c;
    end
  end

  assert_count_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> ($stable(n_act_o) && $stable(act_mask_o) && $stable(off_flat_o)));

  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (int'(n_act_o) >= 2 && int'(n_act_o) <= NCH
                && int'(n_act_o) == $countones(act_mask_o)));

endmodule

// File: rtl/mpwm_balance.sv
module mpwm_balance #(
  parameter int NCH       = 4,
  parameter int PERIOD    = 240,
  parameter int IW        = 8,
  parameter int DW        = 8,
  parameter int NW        = 3,
  parameter int TRIM_SHIFT = 1
) (
  input  logic [DW-1:0]     duty_cmd_i,
  input  logic [NCH*IW-1:0] isen_flat_i,
  input  logic [NCH-1:0]    act_mask_i,
  input  logic [NW-1:0]     n_act_i,
  output logic [NCH*DW-1:0] duty_flat_o
);

  // Named intermediate values, visible to assertions and waveforms
  int total_w;
  int avg_w;

  always_comb begin
    total_w = 0;
    for (int k = 0; k < NCH; k++) begin
      if (act_mask_i[k]) total_w = total_w + int'(isen_flat_i[k*IW +: IW]);
    end
    avg_w = mpwm_pkg::mean_of(total_w, int'(n_act_i));
  end

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      duty_flat_o[k*DW +: DW] = DW'(mpwm_pkg::clamp_to(
        int'(duty_cmd_i) + mpwm_pkg::trim_of(avg_w, int'(isen_flat_i[k*IW +: IW]), TRIM_SHIFT),
        PERIOD));
    end
  end

endmodule

// File: rtl/mpwm_phase.sv
module mpwm_phase #(
  parameter int NCH    = 4,
  parameter int PERIOD = 240,
  parameter int CW     = 8,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [NCH-1:0]    act_mask_i,
  input  logic [NCH*CW-1:0] off_flat_i,
  input  logic [NCH*DW-1:0] duty_flat_i,
  input  logic              tri_i,
  input  logic              low_i,
  output logic [NCH-1:0]    pwm_o,
  output logic [NCH-1:0]    oe_o
);

  logic [CW-1:0]  cnt_q;
  logic           last_w;
  logic [NCH-1:0] on_w;

  assign last_w = (int'(cnt_q) == PERIOD - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!done_i) cnt_q <= '0;
    else if (last_w)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // Per-channel sawtooth: counter shifted back by the channel offset
  for (genvar k = 0; k < NCH; k++) begin : g_chan
    logic [CW-1:0] off_w;
    logic [DW-1:0] duty_w;
    logic [CW:0]   loc_w;
    assign off_w  = off_flat_i[k*CW +: CW];
    assign duty_w = duty_flat_i[k*DW +: DW];
    assign loc_w  = (cnt_q >= off_w) ? ({1'b0, cnt_q} - {1'b0, off_w})
                                     : ({1'b0, cnt_q} + (CW+1)'(PERIOD) - {1'b0, off_w});
    assign on_w[k] = int'(loc_w) < int'(duty_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_o <= '0;
      oe_o  <= '0;
    end else if (!done_i) begin
      pwm_o <= '0;
      oe_o  <= '0;
    end else begin
      oe_o  <= low_i ? act_mask_i : (tri_i ? '0 : act_mask_i);
      pwm_o <= (low_i || tri_i) ? '0 : (on_w & act_mask_i);
    end
  end

  assert_cnt_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && last_w) |=> (cnt_q == '0));

  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !last_w) |=> (int'(cnt_q) == $past(int'(cnt_q)) + 1));

  assert_unused_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((oe_o & ~act_mask_i) == '0) && ((pwm_o & ~act_mask_i) == '0));

  assert_tristate_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_i && !low_i) |=> (oe_o == '0 && pwm_o == '0));

  assert_force_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && low_i) |=> (pwm_o == '0 && oe_o == $past(act_mask_i)));

  assert_ref_channel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !low_i && !tri_i && cnt_q == '0 && duty_flat_i[DW-1:0] != '0) |=> pwm_o[0]);

endmodule

// File: rtl/mpwm_top.sv
module mpwm_top #(
  parameter  int NCH        = 4,
  parameter  int PERIOD     = 240,
  parameter  int IW         = 8,
  parameter  int TRIM_SHIFT = 1,
  localparam int CW         = $clog2(PERIOD),
  localparam int DW         = $clog2(PERIOD + 1),
  localparam int NW         = $clog2(NCH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     duty_cmd_i,
  input  logic [NCH*IW-1:0] isen_i,
  input  logic [NCH-1:2]    chan_unused_i,
  input  logic              tri_req_i,
  input  logic              low_req_i,
  output logic [NCH-1:0]    pwm_o,
  output logic [NCH-1:0]    pwm_oe_o
);

  logic              done_w;
  logic [NW-1:0]     n_act_w;
  logic [NCH-1:0]    act_mask_w;
  logic [NCH*CW-1:0] off_flat_w;
  logic [NCH*DW-1:0] duty_flat_w;

  mpwm_detect #(.NCH(NCH), .PERIOD(PERIOD), .CW(CW), .NW(NW)) detect_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_i    (chan_unused_i),
    .done_o     (done_w),
    .n_act_o    (n_act_w),
    .act_mask_o (act_mask_w),
    .off_flat_o (off_flat_w)
  );

  mpwm_balance #(.NCH(NCH), .PERIOD(PERIOD), .IW(IW), .DW(DW), .NW(NW),
                 .TRIM_SHIFT(TRIM_SHIFT)) balance_i (
    .duty_cmd_i  (duty_cmd_i),
    .isen_flat_i (isen_i),
    .act_mask_i  (act_mask_w),
    .n_act_i     (n_act_w),
    .duty_flat_o (duty_flat_w)
  );

  mpwm_phase #(.NCH(NCH), .PERIOD(PERIOD), .CW(CW), .DW(DW)) phase_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_i      (done_w),
    .act_mask_i  (act_mask_w),
    .off_flat_i  (off_flat_w),
    .duty_flat_i (duty_flat_w),
    .tri_i       (tri_req_i),
    .low_i       (low_req_i),
    .pwm_o       (pwm_o),
    .oe_o        (pwm_oe_o)
  );

  assert_idle_before_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !done_w |=> (pwm_o == '0 && pwm_oe_o == '0));

endmodule

// File: tb/mpwm_top_tb_top.sv
module mpwm_top_tb_top;

  localparam int NCH = 4;
  localparam int PER = 240;
  localparam int IW  = 8;
  localparam int SH  = 1;
  localparam int DW  = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n = 1'b0;
  logic [DW-1:0]     duty_cmd = '0;
  logic [NCH*IW-1:0] isen = '0;
  logic [NCH-1:2]    unused = '0;
  logic              tri_req = 1'b0;
  logic              low_req = 1'b0;
  logic [NCH-1:0]    pwm;
  logic [NCH-1:0]    oe;

  mpwm_top #(.NCH(NCH), .PERIOD(PER), .IW(IW), .TRIM_SHIFT(SH)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .duty_cmd_i    (duty_cmd),
    .isen_i        (isen),
    .chan_unused_i (unused),
    .tri_req_i     (tri_req),
    .low_req_i     (low_req),
    .pwm_o         (pwm),
    .pwm_oe_o      (oe)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  // Behavioural reference model
  bit             m_done = 0;
  int             m_n = 0;
  int             m_cnt = 0;
  logic [NCH-1:0] e_pwm = '0;
  logic [NCH-1:0] e_oe = '0;

  function automatic int floor_shift(int v);
    int d;
    d = 1 << SH;
    if (v >= 0) return v / d;
    return -((-v + d - 1) / d);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_done = 0; m_cnt = 0; e_pwm = '0; e_oe = '0;
    end else if (!m_done) begin
      m_done = 1;
      m_n = 2;
      if (!unused[2]) begin
        m_n = 3;
        if (!unused[3]) m_n = 4;
      end
      m_cnt = 0; e_pwm = '0; e_oe = '0;
    end else begin
      int total, avg;
      total = 0;
      for (int k = 0; k < m_n; k++) total += int'(isen[k*IW +: IW]);
      avg = total / m_n;
      for (int k = 0; k < NCH; k++) begin
        int d, pos;
        d = int'(duty_cmd) + floor_shift(avg - int'(isen[k*IW +: IW]));
        if (d < 0) d = 0;
        if (d > PER) d = PER;
        pos = m_cnt - (k * PER) / m_n;
        if (pos < 0) pos += PER;
        if (k >= m_n)      begin e_oe[k] = 1'b0; e_pwm[k] = 1'b0; end
        else if (low_req)  begin e_oe[k] = 1'b1; e_pwm[k] = 1'b0; end
        else if (tri_req)  begin e_oe[k] = 1'b0; e_pwm[k] = 1'b0; end
        else               begin e_oe[k] = 1'b1; e_pwm[k] = (pos < d); end
      end
      m_cnt = (m_cnt + 1) % PER;
    end
  end

  always @(posedge clk) begin
    #5;
    checks++;
    if (pwm !== e_pwm || oe !== e_oe) begin
      errors++;
      $display("FAIL %s t=%0t pwm=%b oe=%b expected pwm=%b oe=%b",
               tag, $time, pwm, oe, e_pwm, e_oe);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_isen(int c0, int c1, int c2, int c3);
    isen = {IW'(c3), IW'(c2), IW'(c1), IW'(c0)};
  endtask

  task automatic do_reset(logic [NCH-1:2] strap);
    @(negedge clk);
    rst_n = 1'b0;
    unused = strap;
    cycles(3);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired in %s", tag);
    finish_run();
  end

  initial begin
    // R1: reset state at the ports
    cycles(3);
    tag = "R1";
    checks++;
    if (pwm !== '0 || oe !== '0) begin
      errors++;
      $display("FAIL R1 reset pwm=%b oe=%b expected pwm=0000 oe=0000", pwm, oe);
    end
    duty_cmd = 8'd60;
    set_isen(100, 100, 100, 100);
    rst_n = 1'b1;

    // R4: four channels, balanced currents, several periods
    tag = "R4";
    cycles(500);

    // R6: unbalanced currents, mid-range, clamp at PERIOD and at zero
    tag = "R6";
    set_isen(120, 100, 80, 100);
    cycles(500);
    duty_cmd = 8'd250;
    cycles(300);
    duty_cmd = 8'd5;
    cycles(300);
    duty_cmd = 8'd0;
    cycles(250);
    duty_cmd = 8'd120;
    set_isen(0, 255, 40, 200);
    cycles(300);

    // R2: strap change after latching must not change the active count
    tag = "R2";
    unused = 2'b11;
    cycles(300);

    // R7: release request
    tag = "R7";
    tri_req = 1'b1;
    cycles(20);
    tri_req = 1'b0;
    cycles(30);

    // R8: force-low request, alone and together with release
    tag = "R8";
    low_req = 1'b1;
    cycles(20);
    tri_req = 1'b1;
    cycles(20);
    low_req = 1'b0;
    cycles(10);
    tri_req = 1'b0;
    cycles(30);

    // R5: three channels, extreme sample on the unfitted channel
    tag = "R5";
    do_reset(2'b10);
    duty_cmd = 8'd100;
    set_isen(90, 110, 100, 255);
    cycles(500);
    tri_req = 1'b1;
    cycles(5);
    tri_req = 1'b0;
    cycles(250);

    // R3: two channels, channel 3 strap clear but chain broken at channel 2
    tag = "R3";
    do_reset(2'b01);
    duty_cmd = 8'd130;
    set_isen(70, 130, 255, 255);
    cycles(500);
    low_req = 1'b1;
    cycles(10);
    low_req = 1'b0;
    cycles(250);

    // R3: two channels, both optional channels strapped
    do_reset(2'b11);
    duty_cmd = 8'd200;
    set_isen(100, 100, 0, 0);
    cycles(500);

    @(posedge clk);
    #7;
    finish_run();
  end

endmodule